// File: doc/BRIEF.md
# Write-synchronized peripheral control register

This block holds the 32-bit control word of a peripheral whose core logic runs on its own, slower clock. Software reaches it over a simple bus with valid, write, address and data lines. Reads return their data in the same cycle. Most control fields are plain configuration. These fields pass straight to the core as a quasi-static word. The bus may change them only while the peripheral is disabled.

Two bits act in the core domain: the enable bit and the software-reset bit. Each reaches the core clock through a toggle-request handshake with a synchronizer in each direction. A status word reports which of these crossings is still in flight.

A software reset wins over everything else written in the same access. It clears the control word and leaves the core disabled. While the reset is in progress it refuses access to the debug-control register, and it keeps that register's contents.

Top module: `wsync_ctrl_reg`

Address map: 0 is the control word, 1 is the status word (read-only), 2 is the debug-control register, and 3 reads 0. The refusal flag `bus_refused` is valid in the same cycle as the access.

## Requirements
- R1: After the bus reset, the control word, the status word and the debug register all read 0, and `core_enable` is 0.
- R2: A write that changes control bit 1 (enable) reads back at once. Status bit 1 reads 1 from the cycle after the write until the core domain has applied the value. When status bit 1 clears, `core_enable` equals the control word's bit 1.
- R3: A control write whose bit 1 equals the current enable value starts no crossing, and status bit 1 stays 0.
- R4: An enable write that arrives while an earlier enable crossing is busy is held back and sent once that crossing finishes. It is never dropped, so both values reach `core_enable` in order.
- R5: While enable is 0, a control write with bit 0 clear stores every implemented bit. The implemented bits are 31:24, 23, 16, 14:8, 6:5 and 1.
- R6: While enable is 1, the protected bits (31:24, 16, 14:8, 6:5) ignore writes. Bit 23 and bit 1 written in the same access still take effect.
- R7: The unimplemented control bits (22:17, 15, 7 and 4:2) always read 0.
- R8: A control write with bit 0 set discards all its other bits. The control word then reads exactly 0x00000001, and status bit 0 reads 1, until the reset completes.
- R9: When the software reset completes, status bit 0 and control bit 0 clear together. The control word and the status word then read 0, and `core_enable` is 0. The debug register keeps its value.
- R10: While a software reset is pending, access to address 2 is refused: `bus_refused` is 1, reads return 0 and writes have no effect. Reads of addresses 0 and 1 are not refused.
- R11: While a software reset is pending, further control writes change nothing.
- R12: Each software reset produces exactly one `core_swrst_pulse` that is high for one core-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_bus_n | input | 1 | Active-low reset, bus domain |
| clk_core | input | 1 | Core clock |
| rst_core_n | input | 1 | Active-low reset, core domain |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_refused | output | 1 | Access refused during pending reset |
| cfg_word | output | 32 | Control word to the core |
| dbg_word | output | DBG_W | Debug-control register value |
| core_enable | output | 1 | Enable as applied in the core domain |
| core_swrst_pulse | output | 1 | One-cycle reset pulse, core domain |

## Verification
The assertions check the following on every cycle:
- reset precedence, in the control word after an accepted reset;
- the freeze of protected bits while enabled;
- the zero control word at reset completion;
- the refusal and hold of the debug register during a pending reset;
- agreement of `core_enable` with the stored bit when the enable busy flag falls;
- the single-cycle width of the core reset pulse.

Only the bench scenarios can show the remaining behaviour:
- which bits are implemented and which are protected, through sweeps over every bit and over the prescaler and resolution codes;
- that a stalled enable write eventually lands rather than being lost;
- that writing an unchanged enable value leaves the status word idle.

// File: rtl/wsync_pkg.sv
package wsync_pkg;
  localparam int unsigned CTRL_W    = 32;
  localparam int unsigned BIT_SWRST = 0;
  localparam int unsigned BIT_EN    = 1;

  // crossing channels
  localparam int unsigned CH_RST = 0;
  localparam int unsigned CH_EN  = 1;
  localparam int unsigned NUM_CH = 2;

  // address map
  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_STAT = 1;
  localparam int unsigned ADR_DBG  = 2;

  // implemented and enable-protected control bits
  localparam logic [CTRL_W-1:0] IMPL_MASK  = 32'hFF81_7F63;
  localparam logic [CTRL_W-1:0] PROT_MASK  = 32'hFF01_7F60;
  localparam logic [CTRL_W-1:0] SWRST_WORD = CTRL_W'(1) << BIT_SWRST;

  // bits a normal write may change, given the current enable state
  function automatic logic [CTRL_W-1:0] ctrl_wmask(input logic enabled);
    logic [CTRL_W-1:0] m;
    m = IMPL_MASK & ~SWRST_WORD;
    if (enabled) m = m & ~PROT_MASK;
    return m;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_merge(input logic [CTRL_W-1:0] cur,
                                                   input logic [CTRL_W-1:0] wd);
    logic [CTRL_W-1:0] m;
    m = ctrl_wmask(cur[BIT_EN]);
    return (cur & ~m) | (wd & m);
  endfunction

  function automatic logic [CTRL_W-1:0] status_word(input logic rst_busy,
                                                    input logic en_busy);
    logic [CTRL_W-1:0] s;
    s = '0;
    s[BIT_SWRST] = rst_busy;
    s[BIT_EN]    = en_busy;
    return s;
  endfunction
endpackage

// File: rtl/wsync_sync.sv
module wsync_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/wsync_toggle_xfer.sv
module wsync_toggle_xfer #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_src_n,
  input  logic launch,
  output logic busy,
  input  logic clk_dst,
  input  logic rst_dst_n,
  output logic strobe
);
  logic req_q, ack_s;
  logic req_s, dst_q;

  always_ff @(posedge clk_src or negedge rst_src_n) begin
    if (!rst_src_n)  req_q <= 1'b0;
    else if (launch) req_q <= ~req_q;
  end

  wsync_sync #(.STAGES(STAGES)) i_req_sync (
    .clk(clk_dst), .rst_n(rst_dst_n), .d(req_q), .q(req_s));

  always_ff @(posedge clk_dst or negedge rst_dst_n) begin
    if (!rst_dst_n) dst_q <= 1'b0;
    else            dst_q <= req_s;
  end

  assign strobe = req_s ^ dst_q;

  wsync_sync #(.STAGES(STAGES)) i_ack_sync (
    .clk(clk_src), .rst_n(rst_src_n), .d(dst_q), .q(ack_s));

  assign busy = req_q ^ ack_s;
endmodule

// File: rtl/wsync_ctrl_reg.sv
module wsync_ctrl_reg
  import wsync_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DBG_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_bus,
  input  logic              rst_bus_n,
  input  logic              clk_core,
  input  logic              rst_core_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  output logic              bus_refused,
  output logic [CTRL_W-1:0] cfg_word,
  output logic [DBG_W-1:0]  dbg_word,
  output logic              core_enable,
  output logic              core_swrst_pulse
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DBG_W-1:0]  dbg_q;
  logic              pend_en_q, rst_inflight_q, en_sent_q;
  logic [NUM_CH-1:0] launch, busy, strobe;

  // named events
  logic sel_ctrl, sel_stat, sel_dbg;
  logic rst_pending, wr_ctrl, rst_accept, cfg_write, en_change;
  logic rst_done, en_busy, dbg_write;

  always_comb begin
    sel_ctrl    = bus_valid && (bus_addr == ADDR_W'(ADR_CTRL));
    sel_stat    = bus_valid && (bus_addr == ADDR_W'(ADR_STAT));
    sel_dbg     = bus_valid && (bus_addr == ADDR_W'(ADR_DBG));
    rst_pending = ctrl_q[BIT_SWRST];
    wr_ctrl     = sel_ctrl && bus_write && !rst_pending;
    rst_accept  = wr_ctrl && bus_wdata[BIT_SWRST];
    cfg_write   = wr_ctrl && !bus_wdata[BIT_SWRST];
    en_change   = cfg_write && (bus_wdata[BIT_EN] != ctrl_q[BIT_EN]);
    rst_done    = rst_inflight_q && !busy[CH_RST];
    en_busy     = pend_en_q || busy[CH_EN];
    dbg_write   = sel_dbg && bus_write && !rst_pending;
    bus_refused = sel_dbg && rst_pending;
    launch[CH_EN]  = pend_en_q && !busy[CH_EN] && !rst_pending;
    launch[CH_RST] = rst_pending && !rst_inflight_q && !busy[CH_EN];
  end

  // bus-domain state
  always_ff @(posedge clk_bus or negedge rst_bus_n) begin
    if (!rst_bus_n) begin
      ctrl_q         <= '0;
      dbg_q          <= '0;
      pend_en_q      <= 1'b0;
      rst_inflight_q <= 1'b0;
      en_sent_q      <= 1'b0;
    end else begin
      if (rst_done)        ctrl_q <= '0;
      else if (rst_accept) ctrl_q <= SWRST_WORD;
      else if (cfg_write)  ctrl_q <= ctrl_merge(ctrl_q, bus_wdata);

      if (rst_accept)         pend_en_q <= 1'b0;
      else if (en_change)     pend_en_q <= 1'b1;
      else if (launch[CH_EN]) pend_en_q <= 1'b0;

      if (launch[CH_EN]) en_sent_q <= ctrl_q[BIT_EN];

      if (launch[CH_RST]) rst_inflight_q <= 1'b1;
      else if (rst_done)  rst_inflight_q <= 1'b0;

      if (dbg_write) dbg_q <= bus_wdata[DBG_W-1:0];
    end
  end

  // one handshake per crossing bit
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_xfer
    wsync_toggle_xfer #(.STAGES(SYNC_STAGES)) i_xfer (
      .clk_src  (clk_bus),
      .rst_src_n(rst_bus_n),
      .launch   (launch[ch]),
      .busy     (busy[ch]),
      .clk_dst  (clk_core),
      .rst_dst_n(rst_core_n),
      .strobe   (strobe[ch])
    );
  end

  // core-domain application; en_sent_q is held while its crossing is busy
  logic core_en_q, core_pulse_q;
  always_ff @(posedge clk_core or negedge rst_core_n) begin
    if (!rst_core_n) begin
      core_en_q    <= 1'b0;
      core_pulse_q <= 1'b0;
    end else begin
      core_pulse_q <= strobe[CH_RST];
      if (strobe[CH_RST])     core_en_q <= 1'b0;
      else if (strobe[CH_EN]) core_en_q <= en_sent_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)     bus_rdata = ctrl_q;
    else if (sel_stat) bus_rdata = status_word(rst_pending, en_busy);
    else if (sel_dbg && !rst_pending) bus_rdata = CTRL_W'(dbg_q);
  end

  assign cfg_word         = ctrl_q;
  assign dbg_word         = dbg_q;
  assign core_enable      = core_en_q;
  assign core_swrst_pulse = core_pulse_q;
endmodule

// File: rtl/wsync_ctrl_chk.sv
module wsync_ctrl_chk
  import wsync_pkg::*;
#(
  parameter int unsigned DBG_W = 8
) (
  input logic              clk_bus,
  input logic              rst_bus_n,
  input logic              clk_core,
  input logic              rst_core_n,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [DBG_W-1:0]  dbg_q,
  input logic              rst_accept,
  input logic              en_busy,
  input logic              sel_dbg,
  input logic              bus_refused,
  input logic              core_enable,
  input logic              core_swrst_pulse
);
  assert_swrst_discards_R8: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    rst_accept |=> (ctrl_q == SWRST_WORD));

  assert_protected_locked_R6: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (ctrl_q[BIT_EN] && !rst_accept) |=> ((ctrl_q & PROT_MASK) == ($past(ctrl_q) & PROT_MASK)));

  assert_reset_clears_R9: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    $fell(ctrl_q[BIT_SWRST]) |-> (ctrl_q == '0));

  assert_dbg_refused_R10: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (sel_dbg && ctrl_q[BIT_SWRST]) |-> bus_refused);

  assert_dbg_hold_R10: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    ctrl_q[BIT_SWRST] |=> $stable(dbg_q));

  assert_enable_applied_R2: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    ($fell(en_busy) && !ctrl_q[BIT_SWRST]) |-> (core_enable == ctrl_q[BIT_EN]));

  assert_pulse_single_R12: assert property (@(posedge clk_core) disable iff (!rst_core_n)
    core_swrst_pulse |=> (!core_swrst_pulse && !core_enable));
endmodule

bind wsync_ctrl_reg wsync_ctrl_chk #(.DBG_W(DBG_W)) i_chk (
  .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_core(clk_core), .rst_core_n(rst_core_n),
  .ctrl_q(ctrl_q), .dbg_q(dbg_q), .rst_accept(rst_accept), .en_busy(en_busy),
  .sel_dbg(sel_dbg), .bus_refused(bus_refused), .core_enable(core_enable),
  .core_swrst_pulse(core_swrst_pulse));

// File: tb/test_wsync_ctrl_reg.sv
module test_wsync_ctrl_reg;
  logic clk_bus = 0, clk_core = 0, rst_bus_n = 0, rst_core_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, cfg_word;
  logic        bus_refused, core_enable, core_swrst_pulse;
  logic [7:0]  dbg_word;

  int checks = 0, fails = 0, pulses = 0;
  logic seen_en = 0;
  logic [31:0] rd;
  logic        rf;

  always #5 clk_bus = ~clk_bus;
  always #7 clk_core = ~clk_core;

  wsync_ctrl_reg i_wsync_ctrl_reg (.*);

  always @(negedge clk_core) begin
    if (core_swrst_pulse) pulses++;
    if (core_enable) seen_en = 1;
  end

  function automatic bit is_impl(int b);
    return b >= 23 || b == 16 || (b >= 8 && b <= 14) || b == 5 || b == 6 || b == 1;
  endfunction
  function automatic bit is_prot(int b);
    return is_impl(b) && b != 23 && b != 1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_op(logic wr, logic [1:0] a, logic [31:0] wd);
    @(negedge clk_bus);
    bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = wd;
    #1 rd = bus_rdata; rf = bus_refused;
    @(posedge clk_bus); #1 bus_valid = 0; bus_write = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      bus_op(0, 1, 0);
      if (rd == 0) break;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] exp, cfg;
    repeat (3) @(posedge clk_core);
    rst_bus_n = 1; rst_core_n = 1;
    // R1 reset state
    bus_op(0, 0, 0); check("R1 ctrl", rd, 0);
    bus_op(0, 1, 0); check("R1 status", rd, 0);
    bus_op(0, 2, 0); check("R1 dbg", rd, 0);
    check("R1 core_enable", {31'b0, core_enable}, 0);

    // R5 / R7 walk every bit above 1 while disabled
    for (int b = 2; b < 32; b++) begin
      bus_op(1, 0, 32'h1 << b);
      bus_op(0, 0, 0);
      exp = is_impl(b) ? (32'h1 << b) : 32'h0;
      check(is_impl(b) ? "R5 walk" : "R7 unimpl", rd, exp);
    end
    bus_op(1, 0, 32'hFFFF_FFFC); bus_op(0, 0, 0);
    check("R7 all ones", rd, 32'hFF81_7F60);

    // R5 sweep prescaler and resolution codes
    for (int p = 0; p < 8; p++)
      for (int r = 0; r < 4; r++) begin
        bus_op(1, 0, (p << 8) | (r << 5));
        bus_op(0, 0, 0);
        check("R5 sweep", rd, (p << 8) | (r << 5));
      end

    // R2 enable with config
    cfg = 32'h0A00_3560;
    bus_op(1, 0, cfg | 32'h2);
    bus_op(0, 0, 0); check("R2 readback", rd, cfg | 32'h2);
    bus_op(0, 1, 0); check("R2 busy set", rd & 32'h2, 32'h2);
    wait_idle();
    check("R2 status idle", rd, 0);
    check("R2 core_enable", {31'b0, core_enable}, 1);

    // R6 protected ignored while enabled, bit 23 still written
    for (int p = 0; p < 8; p++) begin
      bus_op(1, 0, (32'hFFFF_FFFF & ~32'h1) ^ (p << 8));
      bus_op(0, 0, 0);
      check("R6 locked", rd, cfg | 32'h0080_0002);
      bus_op(1, 0, 32'h2);
      bus_op(0, 0, 0);
      check("R6 bit23 clear", rd, cfg | 32'h2);
    end
    // R3 same enable value starts no crossing
    bus_op(1, 0, 32'h2); bus_op(0, 1, 0); check("R3 no busy", rd, 0);
    bus_op(1, 0, 32'h2); bus_op(0, 1, 0); check("R3 no busy again", rd, 0);

    // R4 back-to-back writes
    bus_op(1, 0, 32'h0); wait_idle();
    check("R4 disabled", {31'b0, core_enable}, 0);
    seen_en = 0;
    bus_op(1, 0, 32'h2);
    bus_op(1, 0, 32'h0);
    bus_op(0, 1, 0); check("R4 busy", rd & 32'h2, 32'h2);
    wait_idle();
    check("R4 first value seen", {31'b0, seen_en}, 1);
    check("R4 last value", {31'b0, core_enable}, 0);
    bus_op(0, 0, 0); check("R4 readback", rd, 0);

    // debug register, then enable and configure before reset
    bus_op(1, 2, 32'hA5); bus_op(0, 2, 0); check("R10 dbg normal", rd, 32'hA5);
    bus_op(1, 0, cfg | 32'h2); wait_idle();
    pulses = 0;

    // R8 reset discards other bits
    bus_op(1, 0, 32'hFFFF_FFFF);
    bus_op(0, 0, 0); check("R8 ctrl", rd, 32'h1);
    check("R10 ctrl read allowed", {31'b0, rf}, 0);
    bus_op(0, 1, 0); check("R8 status", rd & 32'h1, 32'h1);
    check("R10 status read allowed", {31'b0, rf}, 0);
    bus_op(0, 2, 0); check("R10 dbg read refused", {31'b0, rf}, 1);
    check("R10 dbg read zero", rd, 0);
    bus_op(1, 2, 32'h3C); check("R10 dbg write refused", {31'b0, rf}, 1);
    bus_op(1, 0, 32'h0080_0002); bus_op(0, 0, 0);
    check("R11 ctrl unchanged", rd, 32'h1);

    wait_idle();
    check("R9 status", rd, 0);
    bus_op(0, 0, 0); check("R9 ctrl", rd, 0);
    check("R9 core_enable", {31'b0, core_enable}, 0);
    bus_op(0, 2, 0); check("R9 dbg kept", rd, 32'hA5);
    check("R10 refusal ended", {31'b0, rf}, 0);
    repeat (4) @(posedge clk_core);
    check("R12 one pulse", pulses, 1);

    // R8 again from disabled, pulse count R12
    bus_op(1, 0, 32'h0000_0F01); bus_op(0, 0, 0); check("R8 second", rd, 32'h1);
    wait_idle(); repeat (4) @(posedge clk_core);
    check("R12 second pulse", pulses, 2);
    finish_run();
  end
endmodule